// File: doc/BRIEF.md
# Ethernet Receive Control-Frame Filter

This block sits in the receive path of an Ethernet MAC, downstream of preamble and start-delimiter removal. It accepts a byte stream with valid, start-of-frame and end-of-frame markers. A good-status bit accompanies the end-of-frame byte and reports whether the CRC and length checks passed. The block parses each frame's header, skipping up to `VLAN_MAX` stacked VLAN tags. It sorts the frame into one of three classes: a pause frame, some other MAC control frame, or an ordinary client frame. Three configuration bits then decide whether the frame goes on to the client or is terminated.

The data path is a fixed delay line of `DEPTH = 12 + 4*VLAN_MAX + 4` stages. The keep-or-drop verdict for a frame is therefore written into the stage that holds its first byte before that byte leaves. A terminated frame leaves no trace on the output. When a pause frame ends with good status and pause handling is not disabled, the two quanta bytes that follow the opcode are presented to the transmit side with a one-cycle strobe. The bytes of one frame are expected on consecutive cycles, which is how a MAC receive stream delivers them. Idle cycles may separate frames.

Top module: `ctlfrm_filter`

## Requirements
- R1: An ordinary frame is delivered byte for byte, with its start and end markers and its good status. This holds with zero, one or two VLAN tags, each tag being type 0x8100 followed by 2 info bytes. Each byte appears on the output exactly DEPTH cycles (24 by default) after it is presented.
- R2: A frame is a control frame only if the type field right after the tags (byte offset 12 + 4*tags) is 0x88,0x08. It is a pause frame only if the next two bytes are 0x00,0x01. The same byte values anywhere else have no effect.
- R3: A pause frame is terminated when cfg_pause_fwd is 0 and delivered when it is 1, and it is processed in both cases.
- R4: A control frame with any opcode other than 0x0001 is terminated when cfg_ctl_ena is 0 and delivered when it is 1. cfg_ctl_ena never causes a pause frame to be delivered.
- R5: After a pause frame whose end beat carries good status, pause_stb is high for exactly one cycle: the cycle after that end beat. pause_quanta then holds the two bytes after the opcode, with the first byte as the upper half.
- R6: A pause frame whose end beat carries bad status raises no strobe.
- R7: When cfg_pause_ign is 1, a good pause frame raises no strobe.
- R8: A terminated frame produces no output beat at all, and no start or end marker.
- R9: Valid bytes that arrive outside a frame (after an end and before the next start) never reach the output.
- R10: The configuration bits are taken at the start beat of a frame, so changing them during the frame does not affect it.
- R11: A 0x8100 type found after VLAN_MAX tags is treated as the client type, so the frame is ordinary.
- R12: A frame that ends before its verdict point is delivered if no control type was seen. If the control type was seen, the frame follows the cfg_ctl_ena rule.
- R13: While reset is high, and in the cycle after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_good | input | 1 | CRC and length good, meaningful with in_eof |
| in_data | input | 8 | Input byte |
| cfg_pause_fwd | input | 1 | Deliver pause frames to the client |
| cfg_ctl_ena | input | 1 | Deliver non-pause control frames to the client |
| cfg_pause_ign | input | 1 | Do not act on pause frames |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_good | output | 1 | Status carried with the last byte |
| out_data | output | 8 | Output byte |
| pause_stb | output | 1 | One-cycle pause request to transmit |
| pause_quanta | output | 16 | Pause time, valid with pause_stb |

## Verification
The bench builds the block with VLAN_MAX = 2, so the delay is 24 cycles and two tags are the limit. That allows a third tag to be placed past the limit for R11. It sweeps all eight combinations of the three configuration bits, across six frame kinds (ordinary with 0, 1 and 2 tags, pause with 0 and 2 tags, other control with 1 tag) and both status values. Expected beat counts, output cycles, strobe cycles and quanta are computed arithmetically from the requirements. Directed frames add misplaced control bytes, short frames, configuration flips in mid-frame and stray bytes between frames.

// File: rtl/ctlfrm_pkg.sv
package ctlfrm_pkg;

    localparam int ADDR_BYTES = 12;
    localparam logic [15:0] TYPE_VLAN = 16'h8100;
    localparam logic [15:0] TYPE_MACCTL = 16'h8808;
    localparam logic [15:0] OPC_PAUSE = 16'h0001;

    typedef enum logic [3:0] {
        PS_ADDR,
        PS_THI,
        PS_TLO,
        PS_VHI,
        PS_VLO,
        PS_OHI,
        PS_OLO,
        PS_QHI,
        PS_QLO,
        PS_BODY
    } parse_st_e;

    typedef struct packed {
        logic fwd_pause;
        logic ctl_ena;
        logic pause_ign;
    } cfg_t;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic       good;
        logic       keep;
        logic [7:0] data;
    } beat_t;

    // Byte index of the last byte needed for the verdict, plus one.
    function automatic int decide_bytes(input int vlan_max);
        return ADDR_BYTES + 4 * vlan_max + 4;
    endfunction

endpackage

// File: rtl/ctlfrm_parser.sv
module ctlfrm_parser
    import ctlfrm_pkg::*;
#(
    parameter int VLAN_MAX = 2,
    parameter int DEPTH    = decide_bytes(VLAN_MAX),
    parameter int IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_good,
    input  logic [7:0]       in_data,
    input  cfg_t             cfg_live,
    output logic             acc,
    output logic             dec_we,
    output logic [IDX_W-1:0] dec_idx,
    output logic             dec_keep,
    output logic             pause_stb,
    output logic [15:0]      pause_quanta
);

    localparam int VCW = (VLAN_MAX > 0) ? $clog2(VLAN_MAX + 1) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] IDX_ADDR_END = IDX_W'(ADDR_BYTES - 1);

    logic             in_frame_q;
    parse_st_e        st_q, cur_st, nst;
    logic [IDX_W-1:0] idx_q, cur_idx, nidx;
    logic [VCW-1:0]   vlan_q, cur_vlan, nvlan;
    logic [7:0]       hi_q;
    logic             decided_q, cur_decided;
    logic             ctrl_q, cur_ctrl, nctrl;
    logic             pause_q, cur_pause, npause;
    logic             qok_q, cur_qok, nqok;
    logic [15:0]      quanta_q, cur_quanta, nquanta;
    cfg_t             cfg_q, cfg_eff;
    logic [15:0]      field;
    logic             dec_now;
    logic             keep_now;
    logic             stb_d;

    assign acc         = in_valid && (in_sof || in_frame_q);
    assign cur_st      = in_sof ? PS_ADDR : st_q;
    assign cur_idx     = in_sof ? '0 : idx_q;
    assign cur_vlan    = in_sof ? '0 : vlan_q;
    assign cur_decided = in_sof ? 1'b0 : decided_q;
    assign cur_ctrl    = in_sof ? 1'b0 : ctrl_q;
    assign cur_pause   = in_sof ? 1'b0 : pause_q;
    assign cur_qok     = in_sof ? 1'b0 : qok_q;
    assign cur_quanta  = in_sof ? '0 : quanta_q;
    assign cfg_eff     = in_sof ? cfg_live : cfg_q;
    assign field       = {hi_q, in_data};
    assign nidx        = (cur_idx == IDX_LAST) ? cur_idx : cur_idx + 1'b1;

    always_comb begin
        nst      = cur_st;
        nvlan    = cur_vlan;
        nctrl    = cur_ctrl;
        npause   = cur_pause;
        nqok     = cur_qok;
        nquanta  = cur_quanta;
        dec_now  = 1'b0;
        keep_now = 1'b1;
        unique case (cur_st)
            PS_ADDR: begin
                if (cur_idx == IDX_ADDR_END) nst = PS_THI;
            end
            PS_THI: nst = PS_TLO;
            PS_TLO: begin
                if (field == TYPE_VLAN && int'(cur_vlan) < VLAN_MAX) begin
                    nvlan = cur_vlan + 1'b1;
                    nst   = PS_VHI;
                end else if (field == TYPE_MACCTL) begin
                    nctrl = 1'b1;
                    nst   = PS_OHI;
                end else begin
                    dec_now  = 1'b1;
                    keep_now = 1'b1;
                    nst      = PS_BODY;
                end
            end
            PS_VHI: nst = PS_VLO;
            PS_VLO: nst = PS_THI;
            PS_OHI: nst = PS_OLO;
            PS_OLO: begin
                dec_now = 1'b1;
                if (field == OPC_PAUSE) begin
                    npause   = 1'b1;
                    keep_now = cfg_eff.fwd_pause;
                    nst      = PS_QHI;
                end else begin
                    keep_now = cfg_eff.ctl_ena;
                    nst      = PS_BODY;
                end
            end
            PS_QHI: nst = PS_QLO;
            PS_QLO: begin
                nquanta = field;
                nqok    = 1'b1;
                nst     = PS_BODY;
            end
            default: nst = PS_BODY;
        endcase
    end

    // Verdict either at its natural point or, for a short frame, at its end.
    always_comb begin
        dec_we   = acc && !cur_decided && (dec_now || in_eof);
        dec_idx  = cur_idx;
        dec_keep = dec_now ? keep_now : (nctrl ? cfg_eff.ctl_ena : 1'b1);
        stb_d    = acc && in_eof && in_good && npause && nqok && !cfg_eff.pause_ign;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q   <= 1'b0;
            st_q         <= PS_ADDR;
            idx_q        <= '0;
            vlan_q       <= '0;
            hi_q         <= '0;
            decided_q    <= 1'b0;
            ctrl_q       <= 1'b0;
            pause_q      <= 1'b0;
            qok_q        <= 1'b0;
            quanta_q     <= '0;
            cfg_q        <= '0;
            pause_stb    <= 1'b0;
            pause_quanta <= '0;
        end else begin
            pause_stb <= stb_d;
            if (stb_d) pause_quanta <= nquanta;
            if (acc) begin
                in_frame_q <= !in_eof;
                st_q       <= nst;
                idx_q      <= nidx;
                vlan_q     <= nvlan;
                hi_q       <= in_data;
                decided_q  <= cur_decided || dec_we;
                ctrl_q     <= nctrl;
                pause_q    <= npause;
                qok_q      <= nqok;
                quanta_q   <= nquanta;
                cfg_q      <= cfg_eff;
            end
        end
    end

endmodule

// File: rtl/ctlfrm_delay.sv
module ctlfrm_delay
    import ctlfrm_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  beat_t            in_beat,
    input  logic             dec_we,
    input  logic [IDX_W-1:0] dec_idx,
    input  logic             dec_keep,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_good,
    output logic [7:0]       out_data
);

    beat_t last;
    logic  keep_q;
    logic  keep_cur;

    // Stage k receives the start beat of the frame whose byte k is arriving,
    // so the verdict is written there as that beat moves in.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        beat_t q;
        beat_t nxt;
        if (i == 0) begin : g_head
            always_comb begin
                nxt = in_beat;
                if (dec_we && dec_idx == IDX_W'(i)) nxt.keep = dec_keep;
            end
        end else begin : g_body
            always_comb begin
                nxt = g_stage[i-1].q;
                if (dec_we && dec_idx == IDX_W'(i)) nxt.keep = dec_keep;
            end
        end
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= nxt;
        end
    end

    assign last     = g_stage[DEPTH-1].q;
    assign keep_cur = last.sof ? last.keep : keep_q;
    assign out_valid = last.valid && keep_cur;
    assign out_sof   = out_valid && last.sof;
    assign out_eof   = out_valid && last.eof;
    assign out_good  = out_valid && last.good;
    assign out_data  = out_valid ? last.data : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) keep_q <= 1'b0;
        else if (last.valid && last.sof) keep_q <= last.keep;
    end

endmodule

// File: rtl/ctlfrm_filter.sv
module ctlfrm_filter
    import ctlfrm_pkg::*;
#(
    parameter int VLAN_MAX = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_good,
    input  logic [7:0]  in_data,
    input  logic        cfg_pause_fwd,
    input  logic        cfg_ctl_ena,
    input  logic        cfg_pause_ign,
    output logic        out_valid,
    output logic        out_sof,
    output logic        out_eof,
    output logic        out_good,
    output logic [7:0]  out_data,
    output logic        pause_stb,
    output logic [15:0] pause_quanta
);

    localparam int DEPTH = decide_bytes(VLAN_MAX);
    localparam int IDX_W = $clog2(DEPTH);

    cfg_t             cfg_live;
    beat_t            in_beat;
    logic             acc;
    logic             dec_we;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_keep;

    assign cfg_live = '{fwd_pause: cfg_pause_fwd, ctl_ena: cfg_ctl_ena, pause_ign: cfg_pause_ign};

    always_comb begin
        in_beat       = '0;
        in_beat.valid = acc;
        if (acc) begin
            in_beat.sof  = in_sof;
            in_beat.eof  = in_eof;
            in_beat.good = in_good && in_eof;
            in_beat.data = in_data;
        end
    end

    ctlfrm_parser #(
        .VLAN_MAX (VLAN_MAX),
        .DEPTH    (DEPTH),
        .IDX_W    (IDX_W)
    ) u_parser (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_eof       (in_eof),
        .in_good      (in_good),
        .in_data      (in_data),
        .cfg_live     (cfg_live),
        .acc          (acc),
        .dec_we       (dec_we),
        .dec_idx      (dec_idx),
        .dec_keep     (dec_keep),
        .pause_stb    (pause_stb),
        .pause_quanta (pause_quanta)
    );

    ctlfrm_delay #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_delay (
        .clk       (clk),
        .rst       (rst),
        .in_beat   (in_beat),
        .dec_we    (dec_we),
        .dec_idx   (dec_idx),
        .dec_keep  (dec_keep),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_good  (out_good),
        .out_data  (out_data)
    );

endmodule

// File: rtl/ctlfrm_filter_chk.sv
module ctlfrm_filter_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_eof,
    input logic        in_good,
    input logic        out_valid,
    input logic        out_sof,
    input logic        out_eof,
    input logic        pause_stb
);

    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else if (out_valid) open_q <= !out_eof;
    end

    // R5
    stb_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        pause_stb |=> !pause_stb);

    // R5
    stb_after_good_end_chk: assert property (@(posedge clk) disable iff (rst)
        pause_stb |-> $past(in_valid && in_eof && in_good));

    // R13
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !pause_stb));

    // R8
    beat_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sof) |-> open_q);

    // R8
    start_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> !open_q);

endmodule

bind ctlfrm_filter ctlfrm_filter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_eof    (in_eof),
    .in_good   (in_good),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .pause_stb (pause_stb)
);

// File: tb/ctlfrm_filter_tb.sv
module ctlfrm_filter_tb;

    localparam int VLAN_MAX = 2;
    localparam int LAT = 12 + 4 * VLAN_MAX + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_good = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        cfg_pause_fwd = 1'b0, cfg_ctl_ena = 1'b0, cfg_pause_ign = 1'b0;
    logic        out_valid, out_sof, out_eof, out_good;
    logic [7:0]  out_data;
    logic        pause_stb;
    logic [15:0] pause_quanta;

    ctlfrm_filter #(.VLAN_MAX(VLAN_MAX)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_good(in_good), .in_data(in_data), .cfg_pause_fwd(cfg_pause_fwd),
        .cfg_ctl_ena(cfg_ctl_ena), .cfg_pause_ign(cfg_pause_ign),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_good(out_good),
        .out_data(out_data), .pause_stb(pause_stb), .pause_quanta(pause_quanta)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int ncmp = 0;
    int nerr = 0;

    logic [7:0]  o_data [0:255];
    logic        o_sof  [0:255];
    logic        o_eof  [0:255];
    logic        o_good [0:255];
    int          o_cyc  [0:255];
    int          ocnt = 0;
    int          scnt = 0;
    int          scyc = 0;
    logic [15:0] sq = 16'h0;

    always @(negedge clk) begin
        if (out_valid) begin
            if (ocnt < 256) begin
                o_data[ocnt] = out_data;
                o_sof[ocnt]  = out_sof;
                o_eof[ocnt]  = out_eof;
                o_good[ocnt] = out_good;
                o_cyc[ocnt]  = cyc;
            end
            ocnt = ocnt + 1;
        end
        if (pause_stb) begin
            scnt = scnt + 1;
            scyc = cyc;
            sq   = pause_quanta;
        end
    end

    logic [7:0] fb [0:127];
    int flen = 0;
    int sof_cyc = 0;
    int eof_cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        ncmp++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build(input int ntag, input logic [15:0] et, input logic [15:0] opc,
                         input logic [15:0] q, input int total);
        int p;
        for (int i = 0; i < 128; i++) fb[i] = 8'(i * 37 + 5);
        p = 12;
        for (int t = 0; t < ntag; t++) begin
            fb[p]   = 8'h81;
            fb[p+1] = 8'h00;
            fb[p+2] = 8'h00;
            fb[p+3] = 8'(t + 1);
            p += 4;
        end
        fb[p]   = et[15:8];
        fb[p+1] = et[7:0];
        fb[p+2] = opc[15:8];
        fb[p+3] = opc[7:0];
        fb[p+4] = q[15:8];
        fb[p+5] = q[7:0];
        flen = total;
    endtask

    task automatic send(input logic g, input int flip_at);
        ocnt = 0;
        scnt = 0;
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            if (i == flip_at) begin
                cfg_pause_fwd = ~cfg_pause_fwd;
                cfg_ctl_ena   = ~cfg_ctl_ena;
                cfg_pause_ign = ~cfg_pause_ign;
            end
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == flen - 1);
            in_good  = (i == flen - 1) ? g : 1'b0;
            in_data  = fb[i];
            if (i == 0) sof_cyc = cyc;
            if (i == flen - 1) eof_cyc = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        in_good  = 1'b0;
        repeat (LAT + 8) @(negedge clk);
    endtask

    task automatic verify(input bit keep, input bit stb, input logic [15:0] q, input logic g,
                          input string kreq, input string sreq);
        int bad;
        check(ocnt == (keep ? flen : 0), kreq, ocnt, keep ? flen : 0);
        if (keep) begin
            bad = 0;
            for (int i = 0; i < flen; i++) begin
                if (o_data[i] !== fb[i] || o_sof[i] !== (i == 0) ||
                    o_eof[i] !== (i == flen - 1) || o_cyc[i] != sof_cyc + LAT + i)
                    bad++;
            end
            check(bad == 0, "R1", bad, 0);
            check(o_good[flen-1] === g, "R1", int'(o_good[flen-1]), int'(g));
        end
        check(scnt == int'(stb), sreq, scnt, int'(stb));
        if (stb && scnt == 1) begin
            check(scyc == eof_cyc + 1, "R5", scyc, eof_cyc + 1);
            check(sq == q, "R5", int'(sq), int'(q));
        end
    endtask

    task automatic set_cfg(input int c);
        cfg_pause_fwd = c[0];
        cfg_ctl_ena   = c[1];
        cfg_pause_ign = c[2];
    endtask

    initial begin
        #(20 * 200000);
        nerr++;
        ncmp++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

    initial begin
        logic [15:0] q;
        int ntag;
        logic [15:0] et;
        logic [15:0] opc;
        bit keep, stb;
        string kreq, sreq;

        repeat (3) @(negedge clk);
        // R13: outputs low while reset is held
        check(!out_valid && !pause_stb && !out_sof && !out_eof, "R13",
              int'(out_valid) + int'(pause_stb), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !pause_stb && pause_quanta == 16'h0, "R13",
              int'(out_valid) + int'(pause_stb), 0);

        // Sweep: all configurations x frame kinds x status
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 6; k++) begin
                for (int g = 0; g < 2; g++) begin
                    q = 16'h8000 + 16'(k * 256 + c * 16 + g + 3);
                    ntag = (k == 1 || k == 5) ? 1 : ((k == 2 || k == 4) ? 2 : 0);
                    et   = (k >= 3) ? 16'h8808 : 16'h0800;
                    opc  = (k == 5) ? 16'h0002 : 16'h0001;
                    build(ntag, et, opc, q, 64);
                    set_cfg(c);
                    send(g[0], -1);
                    if (k < 3) begin
                        keep = 1'b1; kreq = "R1";
                    end else if (k < 5) begin
                        keep = c[0]; kreq = keep ? "R3" : "R8 R3";
                    end else begin
                        keep = c[1]; kreq = keep ? "R4" : "R8 R4";
                    end
                    stb = (k == 3 || k == 4) && g == 1 && !c[2];
                    if (k == 3 || k == 4) sreq = (g == 0) ? "R6" : (c[2] ? "R7" : "R5");
                    else sreq = "R2";
                    verify(keep, stb, q, g[0], kreq, sreq);
                end
            end
        end

        // R2: control bytes at the wrong offset leave the frame ordinary
        build(0, 16'h0800, 16'h8808, 16'h0001, 60);
        set_cfg(0);
        send(1'b1, -1);
        verify(1'b1, 1'b0, 16'h0, 1'b1, "R2", "R2");

        // R11: third VLAN type beyond the limit is the client type
        build(3, 16'h8808, 16'h0001, 16'h1234, 64);
        set_cfg(0);
        send(1'b1, -1);
        verify(1'b1, 1'b0, 16'h0, 1'b1, "R11", "R11");

        // R12: short ordinary frame ends before verdict point
        build(0, 16'h0800, 16'h0000, 16'h0000, 10);
        set_cfg(0);
        send(1'b0, -1);
        verify(1'b1, 1'b0, 16'h0, 1'b0, "R12", "R12");

        // R12: short frame with control type seen, control disabled then enabled
        build(0, 16'h8808, 16'h0001, 16'h0000, 15);
        set_cfg(0);
        send(1'b1, -1);
        verify(1'b0, 1'b0, 16'h0, 1'b1, "R12", "R12");
        build(0, 16'h8808, 16'h0001, 16'h0000, 15);
        set_cfg(2);
        send(1'b1, -1);
        verify(1'b1, 1'b0, 16'h0, 1'b1, "R12", "R12");

        // R10: configuration flipped mid-frame has no effect on that frame
        build(1, 16'h8808, 16'h0001, 16'hA55A, 64);
        set_cfg(0);
        send(1'b1, 3);
        verify(1'b0, 1'b1, 16'hA55A, 1'b1, "R10", "R10");
        build(0, 16'h8808, 16'h0007, 16'h0000, 64);
        set_cfg(7);
        send(1'b1, 5);
        verify(1'b1, 1'b0, 16'h0, 1'b1, "R10", "R10");

        // R9: valid bytes between frames are discarded
        ocnt = 0;
        scnt = 0;
        set_cfg(3);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = 1'b0;
            in_eof   = (i % 5 == 4);
            in_good  = 1'b1;
            in_data  = 8'(i * 11);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eof   = 1'b0;
        in_good  = 1'b0;
        repeat (LAT + 8) @(negedge clk);
        check(ocnt == 0, "R9", ocnt, 0);
        check(scnt == 0, "R9", scnt, 0);

        // R1: a frame after the stray bytes is still delivered intact
        build(2, 16'h0806, 16'h0000, 16'h0000, 70);
        set_cfg(0);
        send(1'b1, -1);
        verify(1'b1, 1'b0, 16'h0, 1'b1, "R1", "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

endmodule